// File: doc/BRIEF.md
# Ringing-to-Talk Release Sequencer

This block sits on the host side of a solid-state line access switch. It drives the switch's three mode inputs (ringing, test-in, test-out), its data-latch control and its active-low, open-drain shutdown line. Its main job is to take a subscriber line from ringing back to idle/talk. The line must not be left in a bad state while the ringing switch waits for a zero-current crossing before it can open.

Three release orderings can be selected. Make-before-break closes the break switches at once. Break-before-make passes through the all-off input pattern for a timed hold. The third ordering pulls the shutdown line low for the hold and changes the inputs underneath it. The hold length is a tick count supplied with each start request, with a parameterised default of 25 ms. When the sequencer is idle, the host may also request any other line state and latch setting directly.

Top module: `ring_release_seq`

## Requirements
- R1: Under reset, and on leaving it, the mode pattern is 000, the latch control is 0, the shutdown drive-low enable is 0, and busy and done are 0.
- R2: The pattern is {ringing, test-in, test-out}: 100 is ringing, 101 is all-off and 000 is idle/talk. A direct request accepted while idle sets the pattern to `req_pat_i` and the latch control to `req_latch_i` on the next edge.
- R3: Mode 0, and mode 3 which behaves the same, sets the pattern to 000 at the start edge. The block stays busy for the hold, then pulses done.
- R4: Mode 1 sets the pattern to 101 at the start edge and holds it for N cycles. On the N-th following edge it sets the pattern to 000 and pulses done.
- R5: Mode 2 asserts the shutdown drive-low enable at the start edge and leaves the pattern unchanged for that first cycle. The pattern becomes 000 on the next edge. After N cycles the enable drops and done pulses.
- R6: The shutdown data output is always 0, so the line is only ever pulled low or released and is never driven high.
- R7: N is `hold_ticks_i` sampled at the start edge. A value of 0 selects DEF_HOLD, and a value of 1 is raised to 2.
- R8: A start request or a direct request that arrives while busy has no effect on the outputs.
- R9: Done is high for exactly one cycle, and never while busy.
- R10: An abort takes effect on the next edge. It sets the pattern to 000, clears the latch control and the drive-low enable, and ends busy without a done pulse.
- R11: An accepted start clears the latch control to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request the ringing-to-talk release |
| mode_i | input | 2 | Release ordering: 0/3 make-before-break, 1 break-before-make via inputs, 2 via shutdown line |
| hold_ticks_i | input | CNT_W | Hold length in clock ticks (0 selects default) |
| abort_i | input | 1 | Synchronous abort to idle/talk |
| req_i | input | 1 | Direct line-state request (idle only) |
| req_pat_i | input | 3 | Requested {ringing, test-in, test-out} pattern |
| req_latch_i | input | 1 | Requested latch control level |
| ring_o | output | 1 | Ringing mode input to the switch |
| tin_o | output | 1 | Test-in mode input to the switch |
| tout_o | output | 1 | Test-out mode input to the switch |
| latch_o | output | 1 | Latch control (1 freezes switch state) |
| sd_oe_o | output | 1 | Drive-low enable for the shutdown line |
| sd_dat_o | output | 1 | Shutdown line data, tied 0 |
| busy_o | output | 1 | Release sequence in progress |
| done_o | output | 1 | One-cycle pulse when idle/talk has been applied |

## Verification
The bench builds the block with CNT_W=8 and DEF_HOLD=5. At these values the default-hold path, selected by a tick count of zero, finishes in a few cycles instead of five million. This allows the bench to compare the default against explicit holds of 1 (raised to 2), 2 and 3 cycles. The small counter width also keeps every hold edge, the abort in the middle of each break-before-make ordering, and a reset during a shutdown-line hold within a short vector table.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [1:0] {
    REL_MBB     = 2'd0,
    REL_BBM_IN  = 2'd1,
    REL_BBM_SD  = 2'd2,
    REL_MBB_ALT = 2'd3
  } rel_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } seq_state_e;

  localparam logic [2:0] PAT_TALK = 3'b000;
  localparam logic [2:0] PAT_OPEN = 3'b101;

endpackage

// File: rtl/rrs_hold_timer.sv
module rrs_hold_timer #(
  parameter int CNT_W    = 23,
  parameter int DEF_HOLD = 5_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] ticks_i,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_HOLD);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] eff_ticks;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    if (ticks_i == '0)        eff_ticks = DEF_V;
    else if (ticks_i < MIN_V) eff_ticks = MIN_V;
    else                      eff_ticks = ticks_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)            cnt_d = '0;
    else if (load_i)        cnt_d = eff_ticks;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == ONE_V);

  // R7: a loaded hold is never shorter than two ticks
  p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !clear_i |=> cnt_q >= MIN_V);

endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       abort_i,
  input  logic       req_i,
  input  logic [2:0] req_pat_i,
  input  logic       req_latch_i,
  input  logic       last_i,
  output logic       load_o,
  output logic [2:0] pat_o,
  output logic       latch_o,
  output logic       sd_oe_o,
  output logic       busy_o,
  output logic       done_o
);

  seq_state_e state_q, state_d;
  rel_mode_e  mode_q, mode_d;
  logic [2:0] pat_q, pat_d;
  logic       latch_q, latch_d;
  logic       oe_q, oe_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    pat_d   = pat_q;
    latch_d = latch_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
      pat_d   = PAT_TALK;
      latch_d = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_d  = rel_mode_e'(mode_i);
            latch_d = 1'b0;
            state_d = ST_HOLD;
            load_o  = 1'b1;
            unique case (rel_mode_e'(mode_i))
              REL_BBM_IN:           pat_d = PAT_OPEN;
              REL_BBM_SD:           oe_d  = 1'b1;
              REL_MBB, REL_MBB_ALT: pat_d = PAT_TALK;
              default:              pat_d = PAT_TALK;
            endcase
          end else if (req_i) begin
            pat_d   = req_pat_i;
            latch_d = req_latch_i;
          end
        end
        ST_HOLD: begin
          if (mode_q == REL_BBM_SD) pat_d = PAT_TALK;
          if (last_i) begin
            pat_d   = PAT_TALK;
            oe_d    = 1'b0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= REL_MBB;
      pat_q   <= PAT_TALK;
      latch_q <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pat_q   <= pat_d;
      latch_q <= latch_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign pat_o   = pat_q;
  assign latch_o = latch_q;
  assign sd_oe_o = oe_q;
  assign busy_o  = (state_q == ST_HOLD);
  assign done_o  = done_q;

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (pat_o == PAT_TALK) && !sd_oe_o && !busy_o && !done_o && !latch_o);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && (pat_o == PAT_TALK) && !sd_oe_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_open_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (mode_q == REL_BBM_IN) |-> pat_o == PAT_OPEN);

  p_talk_under_sd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_o && $past(sd_oe_o) |-> pat_o == PAT_TALK);

  p_sd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe_o) |-> done_o || $past(abort_i));

endmodule

// File: rtl/ring_release_seq.sv
module ring_release_seq #(
  parameter int CNT_W    = 23,
  parameter int DEF_HOLD = 5_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] hold_ticks_i,
  input  logic             abort_i,
  input  logic             req_i,
  input  logic [2:0]       req_pat_i,
  input  logic             req_latch_i,
  output logic             ring_o,
  output logic             tin_o,
  output logic             tout_o,
  output logic             latch_o,
  output logic             sd_oe_o,
  output logic             sd_dat_o,
  output logic             busy_o,
  output logic             done_o
);

  logic       load;
  logic       last;
  logic [2:0] pat;

  rrs_hold_timer #(.CNT_W(CNT_W), .DEF_HOLD(DEF_HOLD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .clear_i (abort_i),
    .ticks_i (hold_ticks_i),
    .last_o  (last)
  );

  rrs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .abort_i     (abort_i),
    .req_i       (req_i),
    .req_pat_i   (req_pat_i),
    .req_latch_i (req_latch_i),
    .last_i      (last),
    .load_o      (load),
    .pat_o       (pat),
    .latch_o     (latch_o),
    .sd_oe_o     (sd_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign {ring_o, tin_o, tout_o} = pat;
  // open-drain: the data bit is fixed low, only the enable moves
  assign sd_dat_o = 1'b0;

endmodule

// File: tb/ring_release_seq_bench.sv
`timescale 1ns/1ps
module ring_release_seq_bench;

  localparam int CNT_W = 8;
  localparam int NROW  = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [CNT_W-1:0] hold_ticks_i = '0;
  logic abort_i = 1'b0;
  logic req_i = 1'b0;
  logic [2:0] req_pat_i = '0;
  logic req_latch_i = 1'b0;
  logic ring_o, tin_o, tout_o, latch_o, sd_oe_o, sd_dat_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ring_release_seq #(.CNT_W(CNT_W), .DEF_HOLD(5)) u_ring_release_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .hold_ticks_i(hold_ticks_i), .abort_i(abort_i), .req_i(req_i),
    .req_pat_i(req_pat_i), .req_latch_i(req_latch_i), .ring_o(ring_o),
    .tin_o(tin_o), .tout_o(tout_o), .latch_o(latch_o), .sd_oe_o(sd_oe_o),
    .sd_dat_o(sd_dat_o), .busy_o(busy_o), .done_o(done_o)
  );

  // row: start mode hold req rpat rlat abort | epat elat eoe ebusy edone
  localparam logic [23:0] VEC [0:NROW-1] = '{
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b0,1'b0, 3'b100,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd0,8'd3,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b0,1'b0, 3'b100,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'd2,1'b0,3'b000,1'b0,1'b0, 3'b101,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b101,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b0,1'b0, 3'b100,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd2,8'd3,1'b0,3'b000,1'b0,1'b0, 3'b100,1'b0,1'b1,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b1,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b1,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b1,1'b0, 3'b100,1'b1,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'd1,1'b0,3'b000,1'b0,1'b0, 3'b101,1'b0,1'b0,1'b1,1'b0},
    {1'b1,2'd0,8'd9,1'b0,3'b000,1'b0,1'b0, 3'b101,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'd0,1'b1,3'b010,1'b0,1'b0, 3'b010,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd3,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b1,3'b111,1'b1,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b0,1'b0, 3'b100,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd2,8'd4,1'b0,3'b000,1'b0,1'b0, 3'b100,1'b0,1'b1,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b1, 3'b000,1'b0,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'd0,1'b1,3'b100,1'b0,1'b0, 3'b100,1'b0,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'd5,1'b0,3'b000,1'b0,1'b0, 3'b101,1'b0,1'b0,1'b1,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b1, 3'b000,1'b0,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'd0,1'b0,3'b000,1'b0,1'b0, 3'b000,1'b0,1'b0,1'b0,1'b0}
  };

  string TAGS [0:NROW-1] = '{
    "R2", "R3", "R3", "R3", "R3 R9", "R9", "R2", "R4", "R4", "R4",
    "R2", "R5", "R5", "R5", "R5", "R2", "R11 R7", "R8", "R7", "R2",
    "R3 R7", "R8", "R7", "R7", "R7", "R7", "R2", "R5", "R10", "R10",
    "R2", "R4", "R10", "R10"
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_outs(string tag, logic [2:0] ep, logic el, logic eo,
                            logic eb, logic ed);
    checks++;
    if ({ring_o, tin_o, tout_o} !== ep || latch_o !== el || sd_oe_o !== eo ||
        busy_o !== eb || done_o !== ed) begin
      errors++;
      $display("FAIL %s: got pat=%b lat=%b oe=%b busy=%b done=%b, expected pat=%b lat=%b oe=%b busy=%b done=%b",
               tag, {ring_o, tin_o, tout_o}, latch_o, sd_oe_o, busy_o, done_o,
               ep, el, eo, eb, ed);
    end
  endtask

  logic sd_high_seen = 1'b0;
  always @(negedge clk) if (sd_dat_o !== 1'b0) sd_high_seen = 1'b1;

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    check_outs("R1 in reset", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step();
    check_outs("R1 after reset", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      start_i      = VEC[i][23];
      mode_i       = VEC[i][22:21];
      hold_ticks_i = VEC[i][20:13];
      req_i        = VEC[i][12];
      req_pat_i    = VEC[i][11:9];
      req_latch_i  = VEC[i][8];
      abort_i      = VEC[i][7];
      step();
      start_i = 1'b0; req_i = 1'b0; abort_i = 1'b0;
      check_outs(TAGS[i], VEC[i][6:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // start and request together: start wins, latch cleared (R11)
    req_i = 1'b1; req_pat_i = 3'b100; req_latch_i = 1'b1;
    step();
    req_i = 1'b1; req_pat_i = 3'b011; req_latch_i = 1'b1;
    start_i = 1'b1; mode_i = 2'd1; hold_ticks_i = 8'd2;
    step();
    start_i = 1'b0; req_i = 1'b0;
    check_outs("R11 start over request", 3'b101, 1'b0, 1'b0, 1'b1, 1'b0);
    step(); step();
    check_outs("R4 short hold end", 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);

    // reset in the middle of a shutdown-line hold (R1)
    req_i = 1'b1; req_pat_i = 3'b100; req_latch_i = 1'b0;
    step();
    req_i = 1'b0; start_i = 1'b1; mode_i = 2'd2; hold_ticks_i = 8'd20;
    step();
    start_i = 1'b0;
    check_outs("R5 line pulled low", 3'b100, 1'b0, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check_outs("R1 async reset mid-hold", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    rst_n = 1'b1;
    step();
    check_outs("R1 idle after reset", 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);

    checks++;
    if (sd_high_seen) begin
      errors++;
      $display("FAIL R6: got sd_dat_o=1 at some cycle, expected always 0");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule